// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Clock with Frozen Host Copy

This block keeps a running 24-hour time and calendar in packed BCD, from hundredths of a second up to a two-digit year. It is fed by a single-cycle enable that pulses at the crystal rate (nominally 32768 per second). A fractional prescaler turns that enable into a 100 Hz step for the hundredths counter. The seconds, minutes, hours, day of week, date, month and year follow through a carry chain. February is 29 days long in any year divisible by four.

The host never reads the running counters. It sees a separate copy of the time fields, which the block refreshes from the counters in one cycle at each second boundary. Two hold bits let the host change this. A read hold freezes the copy so that a multi-byte read stays coherent. A write hold opens the copy for writing, and releasing the write hold loads the written values into the counters. Neither hold stops timekeeping.

An oscillator-stop bit parks the whole counter chain. A frequency-test bit replaces the seconds LSB with a 512 Hz square wave so that the crystal rate can be measured. The host reaches the block through a synchronous register bus that decodes the low address bits of a 16-byte window at the top of the address space.

Top module: `bcd_snapshot_clock`

## Requirements
- R1: After reset the control register reads 0x20 (oscillator parked, no holds), the time reads 00:00:00, day of week 1, date 01, month 01 and year 00.
- R2: Register offsets: 0 is control (bit 7 write hold, bit 6 read hold, bit 5 oscillator stop, bits 4:0 calibration value, stored and read back only). 1 is seconds, 2 minutes, 3 hours, 4 day (bits 2:0 day of week 1..7, bit 6 frequency test, other bits read 0), 5 date, 6 month, 7 year. Offsets 8 to 15 read 0x00. Read data appears one clock after the request.
- R3: With the enable high every cycle, the seconds counter advances exactly OSC_HZ enables after the hundredths phase was restarted. Every field of the host copy is then loaded from the counters in the single following cycle.
- R4: The counters roll over in BCD: 59 seconds to 00, 59 minutes to 00, 23 hours to 00. Day of week runs 7 to 1. Date rolls past 30 in months 04, 06, 09 and 11, past 31 in the other months, and past 28 in February, or past 29 in a year whose BCD value is divisible by 4. Month runs 12 to 01, and year runs 99 to 00.
- R5: While the read hold is set, the host copy does not change, but the counters keep running. After the hold is cleared, the copy shows the current time at the next second boundary.
- R6: A hold bit written in the same cycle as a copy refresh does not block that refresh. A hold bit written one cycle earlier blocks it.
- R7: Writes to offsets 1 to 7, including the frequency-test bit, take effect only while the write hold is set. Otherwise they leave the copy and the test bit unchanged.
- R8: Clearing the write hold loads the host copy into the counters, zeroes the hundredths and restarts the sub-second phase.
- R9: While the oscillator-stop bit is set, the counters and the prescaler do not advance. After the bit is cleared, counting continues from the stopped phase.
- R10: While the frequency-test bit is set, seconds bit 0 reads a square wave that toggles every OSC_HZ/1024 enables (512 Hz at 32768).
- R11: A field holding an illegal BCD digit, or a value above its maximum, goes to its lowest legal value and carries on its next increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One-cycle enable at the crystal rate |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Register offset within the 16-byte window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
A wrong carry or month-length decision in the counter chain only shows up when it is copied out. That happens in the cycle after the second boundary, so the bench reads every field once each boundary has passed. The test cases are chosen so that the rollovers cascade through all fields at once.

The bench resets the sub-second phase with each write-hold release, which makes the boundary cycle exact. A hold bit that is sampled one cycle early or late then shows up as the wrong seconds value, read straight after the race. A prescaler that keeps counting under oscillator stop shows up as extra seconds once the clock is restarted.

// File: rtl/bcdclk_pkg.sv
package bcdclk_pkg;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [2:0] dow;
    logic [7:0] date;
    logic [7:0] mon;
    logic [7:0] year;
  } bcd_time_t;

  localparam bcd_time_t TIME_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                       dow: 3'd1, date: 8'h01, mon: 8'h01,
                                       year: 8'h00};

  // Returns {carry, next}. An illegal digit or a value at or above the
  // limit wraps to the lowest value and carries.
  function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                          input logic [7:0] lo,
                                          input logic [7:0] hi);
    logic [8:0] r;
    if (v[3:0] > 4'd9 || v[7:4] > 4'd9 || v >= hi) r = {1'b1, lo};
    else if (v[3:0] == 4'd9) r = {1'b0, v[7:4] + 4'd1, 4'd0};
    else r = {1'b0, v + 8'd1};
    return r;
  endfunction

  function automatic logic [7:0] bcd_next(input logic [7:0] v,
                                          input logic [7:0] lo,
                                          input logic [7:0] hi);
    logic [8:0] r;
    r = bcd_step(v, lo, hi);
    return r[7:0];
  endfunction

  function automatic logic [2:0] dow_next(input logic [2:0] d);
    return (d >= 3'd7 || d == 3'd0) ? 3'd1 : d + 3'd1;
  endfunction

  // 10 = 2 (mod 4), so the value mod 4 is (2*tens + units) mod 4.
  function automatic logic is_leap(input logic [7:0] y);
    return y[1:0] == {y[4], 1'b0};
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon,
                                            input logic [7:0] year);
    logic [7:0] d;
    if (mon == 8'h02) d = is_leap(year) ? 8'h29 : 8'h28;
    else if (mon == 8'h04 || mon == 8'h06 || mon == 8'h09 || mon == 8'h11) d = 8'h30;
    else d = 8'h31;
    return d;
  endfunction

endpackage

// File: rtl/bcdclk_prescale.sv
module bcdclk_prescale #(
  parameter int OSC_HZ   = 32768,
  parameter int CENTI_HZ = 100,
  parameter int TEST_HZ  = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_en,
  input  logic run,
  input  logic restart,
  output logic centi_tick,
  output logic ftest
);
  localparam int ACC_W   = $clog2(OSC_HZ) + 2;
  localparam int FT_HALF = (OSC_HZ / TEST_HZ) > 0 ? (OSC_HZ / TEST_HZ) : 1;
  localparam int FT_W    = $clog2(FT_HALF) + 1;

  logic [ACC_W-1:0] acc, acc_sum;
  logic [FT_W-1:0]  ft_cnt;
  logic             step, wrap;

  assign step       = osc_en && run;
  assign acc_sum    = acc + ACC_W'(CENTI_HZ);
  assign wrap       = acc_sum >= ACC_W'(OSC_HZ);
  assign centi_tick = step && wrap && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) acc <= '0;
    else if (step) acc <= wrap ? acc_sum - ACC_W'(OSC_HZ) : acc_sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ft_cnt <= '0;
      ftest  <= 1'b0;
    end else if (step) begin
      if (ft_cnt == FT_W'(FT_HALF - 1)) begin
        ft_cnt <= '0;
        ftest  <= !ftest;
      end else begin
        ft_cnt <= ft_cnt + FT_W'(1);
      end
    end
  end
endmodule

// File: rtl/bcdclk_chain.sv
module bcdclk_chain
  import bcdclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      centi_tick,
  input  logic      load,
  input  bcd_time_t load_val,
  output bcd_time_t now,
  output logic [7:0] centi,
  output logic      sec_pulse
);
  logic [8:0] st_centi, st_sec, st_min, st_hour, st_date, st_mon;

  always_comb begin
    st_centi = bcd_step(centi,    8'h00, 8'h99);
    st_sec   = bcd_step(now.sec,  8'h00, 8'h59);
    st_min   = bcd_step(now.min,  8'h00, 8'h59);
    st_hour  = bcd_step(now.hour, 8'h00, 8'h23);
    st_date  = bcd_step(now.date, 8'h01, month_days(now.mon, now.year));
    st_mon   = bcd_step(now.mon,  8'h01, 8'h12);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      now       <= TIME_RESET;
      centi     <= 8'h00;
      sec_pulse <= 1'b0;
    end else if (load) begin
      now       <= load_val;
      centi     <= 8'h00;
      sec_pulse <= 1'b0;
    end else begin
      sec_pulse <= centi_tick && st_centi[8];
      if (centi_tick) begin
        centi <= st_centi[7:0];
        if (st_centi[8]) begin
          now.sec <= st_sec[7:0];
          if (st_sec[8]) begin
            now.min <= st_min[7:0];
            if (st_min[8]) begin
              now.hour <= st_hour[7:0];
              if (st_hour[8]) begin
                now.dow  <= dow_next(now.dow);
                now.date <= st_date[7:0];
                if (st_date[8]) begin
                  now.mon <= st_mon[7:0];
                  if (st_mon[8]) now.year <= bcd_next(now.year, 8'h00, 8'h99);
                end
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/bcd_snapshot_clock.sv
module bcd_snapshot_clock
  import bcdclk_pkg::*;
#(
  parameter int OSC_HZ = 32768,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_en,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_DAY  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_YEAR = ADDR_W'(7);

  logic       wh_q, rh_q, stop_q, fte_q;
  logic [4:0] cal_q;
  bcd_time_t  user_q, now_t;
  logic [7:0] centi, rd_mux;
  logic       wr_en, rd_en, ctrl_wr, load, centi_tick, sec_pulse, ftest;

  assign wr_en   = bus_en && bus_we;
  assign rd_en   = bus_en && !bus_we;
  assign ctrl_wr = wr_en && bus_addr == A_CTRL;
  assign load    = ctrl_wr && wh_q && !bus_wdata[7];

  bcdclk_prescale #(.OSC_HZ(OSC_HZ)) u_prescale (
    .clk(clk), .rst(rst), .osc_en(osc_en), .run(!stop_q), .restart(load),
    .centi_tick(centi_tick), .ftest(ftest)
  );

  bcdclk_chain u_chain (
    .clk(clk), .rst(rst), .centi_tick(centi_tick), .load(load),
    .load_val(user_q), .now(now_t), .centi(centi), .sec_pulse(sec_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wh_q   <= 1'b0;
      rh_q   <= 1'b0;
      stop_q <= 1'b1;
      cal_q  <= 5'd0;
      fte_q  <= 1'b0;
      user_q <= TIME_RESET;
    end else begin
      if (ctrl_wr) {wh_q, rh_q, stop_q, cal_q} <= bus_wdata;
      if (wr_en && wh_q && bus_addr == A_DAY) fte_q <= bus_wdata[6];
      if (sec_pulse && !wh_q && !rh_q) begin
        user_q <= now_t;
      end else if (wr_en && wh_q) begin
        case (bus_addr)
          A_SEC:   user_q.sec  <= bus_wdata;
          A_MIN:   user_q.min  <= bus_wdata;
          A_HOUR:  user_q.hour <= bus_wdata;
          A_DAY:   user_q.dow  <= bus_wdata[2:0];
          A_DATE:  user_q.date <= bus_wdata;
          A_MON:   user_q.mon  <= bus_wdata;
          A_YEAR:  user_q.year <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    case (bus_addr)
      A_CTRL:  rd_mux = {wh_q, rh_q, stop_q, cal_q};
      A_SEC:   rd_mux = {user_q.sec[7:1], fte_q ? ftest : user_q.sec[0]};
      A_MIN:   rd_mux = user_q.min;
      A_HOUR:  rd_mux = user_q.hour;
      A_DAY:   rd_mux = {1'b0, fte_q, 3'b000, user_q.dow};
      A_DATE:  rd_mux = user_q.date;
      A_MON:   rd_mux = user_q.mon;
      A_YEAR:  rd_mux = user_q.year;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= 8'h00;
    else if (rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/bcdclk_checks.sv
module bcdclk_checks
  import bcdclk_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       wh,
  input logic       rh,
  input logic       stop,
  input logic       load,
  input logic       sec_pulse,
  input bcd_time_t  user,
  input bcd_time_t  now,
  input logic [7:0] centi
);
  AST_REFRESH_SYNC: assert property (@(posedge clk) disable iff (rst)
    $past(sec_pulse && !wh && !rh) |-> user == $past(now)); // R3
  AST_SEC_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |-> centi == 8'h00); // R3
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(rh && !wh) |-> $stable(user)); // R5
  AST_NO_WRITE_UNHELD: assert property (@(posedge clk) disable iff (rst)
    $past(!wh && !sec_pulse) |-> $stable(user)); // R7
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
    $past(load) |-> (now == $past(user) && centi == 8'h00)); // R8
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    $past(stop && !load) |-> $stable(centi)); // R9
endmodule

bind bcd_snapshot_clock bcdclk_checks u_checks (
  .clk(clk), .rst(rst), .wh(wh_q), .rh(rh_q), .stop(stop_q), .load(load),
  .sec_pulse(sec_pulse), .user(user_q), .now(now_t), .centi(centi)
);

// File: tb/bcd_snapshot_clock_test.sv
`timescale 1ns/1ps
module bcd_snapshot_clock_test;
  localparam int HZ = 2048;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_en = 1'b1;
  logic       bus_en = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = !clk;

  bcd_snapshot_clock #(.OSC_HZ(HZ), .ADDR_W(4)) uut (
    .clk(clk), .rst(rst), .osc_en(osc_en), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // sec,min,hour,dow,date,mon,year | expected after one second, same order
  localparam logic [111:0] VEC [11] = '{
    112'h59_59_23_07_31_12_99_00_00_00_01_01_01_00,
    112'h59_59_23_02_28_02_24_00_00_00_03_29_02_24,
    112'h59_59_23_05_28_02_23_00_00_00_06_01_03_23,
    112'h59_59_23_04_30_04_05_00_00_00_05_01_05_05,
    112'h09_19_09_03_15_07_42_10_19_09_03_15_07_42,
    112'h59_59_23_06_29_02_00_00_00_00_07_01_03_00,
    112'h3C_10_05_01_10_06_10_00_11_05_01_10_06_10,
    112'h59_59_11_02_30_06_07_00_00_12_02_30_06_07,
    112'h59_59_23_01_31_01_19_00_00_00_02_01_02_19,
    112'h59_5A_08_03_09_09_09_00_00_09_03_09_09_09,
    112'h59_59_23_03_30_11_50_00_00_00_04_01_12_50
  };

  function automatic logic [7:0] vb(input logic [111:0] v, input int k);
    return v[111-8*k -: 8];
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] dy, input logic [7:0] dt, input logic [7:0] mo,
                          input logic [7:0] yr);
    wr(4'd0, 8'h80);
    wr(4'd1, s); wr(4'd2, m); wr(4'd3, h); wr(4'd4, dy);
    wr(4'd5, dt); wr(4'd6, mo); wr(4'd7, yr);
    wr(4'd0, 8'h00);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, prev;
    int toggles;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(4'd0, d); check("R1 ctrl", d, 8'h20);
    rd(4'd1, d); check("R1 sec", d, 8'h00);
    rd(4'd3, d); check("R1 hour", d, 8'h00);
    rd(4'd4, d); check("R1 day", d, 8'h01);
    rd(4'd5, d); check("R1 date", d, 8'h01);
    rd(4'd6, d); check("R1 month", d, 8'h01);
    rd(4'd7, d); check("R1 year", d, 8'h00);

    // R2 control readback and unused offset
    wr(4'd0, 8'h1F);
    rd(4'd0, d); check("R2 ctrl readback", d, 8'h1F);
    rd(4'd15, d); check("R2 unused offset", d, 8'h00);
    wr(4'd0, 8'h00);

    // R3 R4 R8 R11: vectors of rollover cases
    for (int i = 0; i < 11; i++) begin
      set_time(vb(VEC[i], 0), vb(VEC[i], 1), vb(VEC[i], 2), vb(VEC[i], 3),
               vb(VEC[i], 4), vb(VEC[i], 5), vb(VEC[i], 6));
      repeat (2100) @(negedge clk);
      rd(4'd1, d); check("R4 R8 R11 sec", d, vb(VEC[i], 7));
      rd(4'd2, d); check("R4 R11 min", d, vb(VEC[i], 8));
      rd(4'd3, d); check("R4 hour", d, vb(VEC[i], 9));
      rd(4'd4, d); check("R4 dow", d, vb(VEC[i], 10));
      rd(4'd5, d); check("R4 date", d, vb(VEC[i], 11));
      rd(4'd6, d); check("R4 month", d, vb(VEC[i], 12));
      rd(4'd7, d); check("R4 year", d, vb(VEC[i], 13));
    end

    // R6: hold one cycle before the refresh blocks it
    set_time(8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    repeat (2046) @(negedge clk);
    wr(4'd0, 8'h40);
    repeat (20) @(negedge clk);
    rd(4'd1, d); check("R6 early hold blocks", d, 8'h30);
    wr(4'd0, 8'h00);

    // R6 R5: hold in the refresh cycle lets it complete, then freezes
    set_time(8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    repeat (2047) @(negedge clk);
    wr(4'd0, 8'h40);
    rd(4'd1, d); check("R6 same-cycle hold", d, 8'h31);
    repeat (3000) @(negedge clk);
    rd(4'd1, d); check("R5 frozen copy", d, 8'h31);
    wr(4'd0, 8'h00);
    repeat (1200) @(negedge clk);
    rd(4'd1, d); check("R5 resume after hold", d, 8'h33);
    // R3: exact boundary, one cycle before and one after the refresh
    set_time(8'h40, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    repeat (2047) @(negedge clk);
    rd(4'd1, d); check("R3 before refresh", d, 8'h40);
    rd(4'd1, d); check("R3 after refresh", d, 8'h41);

    // R9 oscillator stop
    set_time(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(4'd0, 8'h20);
    repeat (5000) @(negedge clk);
    rd(4'd1, d); check("R9 stopped", d, 8'h20);
    wr(4'd0, 8'h00);
    repeat (2200) @(negedge clk);
    rd(4'd1, d); check("R9 resumed", d, 8'h21);

    // R10 frequency test wave on seconds bit 0
    set_time(8'h00, 8'h00, 8'h00, 8'h41, 8'h01, 8'h01, 8'h00);
    rd(4'd4, d); check("R10 day reg test bit", d, 8'h41);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 4'd1;
    @(negedge clk);
    prev = bus_rdata;
    toggles = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (bus_rdata[0] != prev[0]) toggles++;
      prev = bus_rdata;
    end
    bus_en = 1'b0;
    check("R10 toggle count", (toggles >= 30 && toggles <= 33) ? 8'h01 : 8'h00, 8'h01);
    wr(4'd0, 8'h80); wr(4'd4, 8'h01); wr(4'd0, 8'h00);
    rd(4'd4, d); check("R10 test bit cleared", d, 8'h01);

    // R7 writes without write hold are ignored
    rd(4'd1, prev);
    wr(4'd1, 8'h45);
    wr(4'd4, 8'h47);
    rd(4'd1, d); check("R7 sec write ignored", d, prev);
    rd(4'd4, d); check("R7 day write ignored", d, 8'h01);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule